// File: doc/BRIEF.md
# Bit-Sliced Ripple Four-Function ALU

A purely combinational arithmetic and logic unit of parameterised width (8 bits by default). It is built as a chain of identical one-bit slices. Every slice receives one bit of each operand, a carry from the slice below it and the shared 2-bit operation code. Each slice returns one result bit and a carry to the slice above it. The carry ripples from bit 0 up to the most significant bit. Only the carry leaving the top slice is visible at the block's edge.

Subtraction reuses the adder. Each slice inverts its B bit, and the low bit of the operation code enters the carry input of slice 0, which supplies the +1 of the two's-complement negation. During the two logical operations, every slice forces its outgoing carry to zero. The carry output is therefore clean even for the AND code, whose low code bit still drives a 1 into slice 0.

Top module: `ripple_alu`

## Requirements
- R1: With op_i = 2'b00 (add), res_o equals (a_i + b_i) mod 2^WIDTH and carry_o equals bit WIDTH of the full sum.
- R2: With op_i = 2'b01 (subtract), res_o equals (a_i - b_i) mod 2^WIDTH. It is formed as a_i + ~b_i + 1. carry_o is 1 exactly when no borrow occurs, that is when a_i >= b_i unsigned.
- R3: With op_i = 2'b10 (OR), res_o equals a_i | b_i and carry_o is 0. Every inter-slice carry is also 0.
- R4: With op_i = 2'b11 (AND), res_o equals a_i & b_i and carry_o is 0, even though op_i[0] = 1 drives the carry into slice 0.
- R5: A carry generated at bit 0 ripples through every slice. 8'hFF + 8'h01 gives res_o = 8'h00 with carry_o = 1.
- R6: With both operands 8'hFF, the four codes give the following results. Add gives 8'hFE with carry 1. Subtract gives 8'h00 with carry 1. OR gives 8'hFF with carry 0. AND gives 8'hFF with carry 0.
- R7: The block holds no state. Any change on a_i, b_i or op_i reaches res_o and carry_o without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 OR, 11 AND |
| res_o | output | WIDTH | Result bus |
| carry_o | output | 1 | Carry out of the most significant slice |

## Verification
The assertions sit at the top level and are evaluated whenever an input changes. They check three things for every operand pair presented: the add sum and carry against a full-width sum, the subtract no-borrow carry against an unsigned compare, and that logical codes leave every inter-slice carry at zero. Only the bench's scenarios can show the specific ripple cases: the full-length carry from bit 0, the all-ones operands under all four codes, and the zero-borrow edge at equal operands. The bench also shows that outputs follow inputs with no clock edge between them.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_OR  = 2'b10,
    OP_AND = 2'b11
  } op_e;
endpackage

// File: rtl/alu_b_cond.sv
module alu_b_cond (
  input  logic b_i,
  input  logic invert_i,
  output logic b_o
);
  assign b_o = invert_i ? ~b_i : b_i;
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  op_e  op_i,
  output logic r_o,
  output logic c_o
);
  logic b_eff, sum, fa_c;

  alu_b_cond u_bcond (
    .b_i      (b_i),
    .invert_i (op_i == OP_SUB),
    .b_o      (b_eff)
  );

  alu_full_adder u_fa (
    .a_i (a_i),
    .b_i (b_eff),
    .c_i (c_i),
    .s_o (sum),
    .c_o (fa_c)
  );

  always_comb begin
    unique case (op_i)
      OP_OR:   r_o = a_i | b_i;
      OP_AND:  r_o = a_i & b_i;
      default: r_o = sum;
    endcase
  end

  // logical codes kill the carry so the ripple stays clean
  assign c_o = op_i[1] ? 1'b0 : fa_c;
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  localparam int CW = WIDTH + 1;

  op_e           op;
  logic [CW-1:0] carry_w;

  assign op         = op_e'(op_i);
  assign carry_w[0] = op_i[0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (carry_w[i]),
      .op_i (op),
      .r_o  (res_o[i]),
      .c_o  (carry_w[i+1])
    );
  end

  assign carry_o = carry_w[WIDTH];

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == 2'b00)
        AST_ADD_SUM: assert ({carry_o, res_o} == ({1'b0, a_i} + {1'b0, b_i})); // R1
      if (op_i == 2'b01)
        AST_SUB_NOBORROW: assert (carry_o == (a_i >= b_i)); // R2
      if (op_i == 2'b01)
        AST_SUB_DIFF: assert (res_o == WIDTH'(a_i - b_i)); // R2
      if (op_i[1])
        AST_LOGIC_NO_CARRY: assert (carry_w[CW-1:1] == '0); // R3
      if (op_i == 2'b11)
        AST_AND_RESULT: assert (res_o == (a_i & b_i) && !carry_o); // R4
    end
  end
endmodule

// File: tb/sim_ripple_alu.sv
module sim_ripple_alu;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b, res;
  logic [1:0]   op;
  logic         co;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  ripple_alu #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .op_i(op), .res_o(res), .carry_o(co)
  );

  // {op, a, b, exp_res, exp_co}
  localparam logic [26:0] VEC [15] = '{
    {2'b00, 8'h03, 8'h05, 8'h08, 1'b0},
    {2'b00, 8'hFF, 8'h01, 8'h00, 1'b1},
    {2'b00, 8'hFF, 8'hFF, 8'hFE, 1'b1},
    {2'b00, 8'h80, 8'h80, 8'h00, 1'b1},
    {2'b01, 8'h05, 8'h03, 8'h02, 1'b1},
    {2'b01, 8'h03, 8'h05, 8'hFE, 1'b0},
    {2'b01, 8'hFF, 8'hFF, 8'h00, 1'b1},
    {2'b01, 8'h00, 8'h00, 8'h00, 1'b1},
    {2'b01, 8'h00, 8'h01, 8'hFF, 1'b0},
    {2'b10, 8'hF0, 8'h0F, 8'hFF, 1'b0},
    {2'b10, 8'hFF, 8'hFF, 8'hFF, 1'b0},
    {2'b10, 8'hA5, 8'h3C, 8'hBD, 1'b0},
    {2'b11, 8'hFF, 8'hFF, 8'hFF, 1'b0},
    {2'b11, 8'h00, 8'h00, 8'h00, 1'b0},
    {2'b11, 8'hA5, 8'h3C, 8'h24, 1'b0}
  };

  task automatic check(input string req, input logic [W-1:0] er, input logic ec);
    total++;
    if (res !== er || co !== ec) begin
      bad++;
      $display("FAIL %s: op=%b a=%h b=%h got res=%h co=%b exp res=%h co=%b",
               req, op, a, b, res, co, er, ec);
    end
  endtask

  function automatic logic [W:0] model(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    case (o)
      2'b00:   return {1'b0, x} + {1'b0, y};
      2'b01:   return {x >= y, W'(x - y)};
      2'b10:   return {1'b0, x | y};
      default: return {1'b0, x & y};
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: cyc=%0d exp below 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W:0] e;
    a = '0; b = '0; op = 2'b00;
    #20 rst_ni = 1'b1;
    check("R1 initial zero inputs", 8'h00, 1'b0);

    foreach (VEC[i]) begin
      @(negedge clk);
      {op, a, b} = VEC[i][26:9];
      #1;
      check(req_of(op), VEC[i][8:1], VEC[i][0]);
    end

    // R5: full-length ripple
    @(negedge clk); op = 2'b00; a = 8'hFF; b = 8'h01; #1;
    check("R5 ripple", 8'h00, 1'b1);
    a = 8'h7F; #1;
    check("R5 ripple to msb", 8'h80, 1'b0);

    // R6: all-ones under each code
    a = 8'hFF; b = 8'hFF;
    op = 2'b00; #1; check("R6 add", 8'hFE, 1'b1);
    op = 2'b01; #1; check("R6 sub", 8'h00, 1'b1);
    op = 2'b10; #1; check("R6 or",  8'hFF, 1'b0);
    op = 2'b11; #1; check("R6 and", 8'hFF, 1'b0);

    // R7: outputs follow inputs between clock edges
    @(posedge clk); #1;
    op = 2'b00; a = 8'h10; b = 8'h20; #1;
    check("R7 no clock", 8'h30, 1'b0);
    b = 8'hF0; #1;
    check("R7 no clock carry", 8'h00, 1'b1);

    // random sweep against model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      op = 2'(k % 4);
      a = W'($urandom);
      b = W'($urandom);
      #1;
      e = model(op, a, b);
      check(req_of(op), e[W-1:0], e[W]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule